// File: doc/BRIEF.md
# Flash Power-Down and Warm-Up Sequencer

This block decides when an embedded flash controller is powered across the CPU's low-power modes. Two control inputs from a setup register select the policy. `manual_en` allows flash power at all. `auto_en` lets an idle/sleep halt switch flash power off. Entering stop mode with `manual_en` at 1 always removes flash power. When a mode that removed flash power is released, power returns. A warm-up counter then runs while the CPU is held in wait. The counter runs on the fast clock when `clk_sel` is 0, and on a low-frequency enable tick when `clk_sel` is 1. A latched interrupt may be taken only after the wait has ended, and only when the master interrupt enable is set.

The state machine has eight states:
- `ST_RUN`: normal execution.
- `ST_HALT_KEEP`: idle/sleep with the power left as it was.
- `ST_HALT_OFF`: idle/sleep with the power removed.
- `ST_STOP_OFF`: stop mode with the power forced off.
- `ST_STOP_KEEP`: stop mode while the power was already off.
- `ST_OSC_WARM`: oscillator settling, with a flash warm-up to follow.
- `ST_OSC_RUN`: oscillator settling, with no flash warm-up to follow.
- `ST_WARM`: flash warm-up with the CPU waiting.

The transitions are:
- RUN→STOP_OFF on `stop_enter` with `manual_en`=1.
- RUN→STOP_KEEP on `stop_enter` with `manual_en`=0.
- RUN→HALT_OFF on `halt_enter` with both control bits at 1.
- RUN→HALT_KEEP on `halt_enter` otherwise.
- HALT_OFF→WARM on `halt_release`.
- HALT_KEEP→RUN on `halt_release`.
- STOP_OFF→OSC_WARM and STOP_KEEP→OSC_RUN on `stop_release`.
- OSC_WARM→WARM and OSC_RUN→RUN on `osc_ready`.
- WARM→RUN when the counter overflows.

If `stop_enter` and `halt_enter` arrive in the same cycle, stop wins.

Top module: `flash_pwr_seq`

## Requirements
- R1: After reset the block is in normal execution: `cpu_wait`=0, `busy`=0, and `flash_pwr_on` equals `manual_en`.
- R2: With `manual_en`=0, `flash_pwr_on` is 0 on every mode entry and release, and no CPU wait occurs.
- R3: With `manual_en`=1 and `auto_en`=1, an idle/sleep entry drives `flash_pwr_on` to 0 until release.
- R4: Releasing a halt that removed flash power sets `flash_pwr_on`=1 and asserts `cpu_wait` for exactly 2^10 clock cycles when `clk_sel`=0. After that, `flash_pwr_on` stays 1.
- R5: With `clk_sel`=1, the warm-up lasts exactly 2^3 cycles in which `low_tick` is 1.
- R6: With `auto_en`=0, an idle/sleep entry leaves `flash_pwr_on` unchanged, and release causes no CPU wait.
- R7: With `manual_en`=1, a stop entry drives `flash_pwr_on` to 0 whatever `auto_en` holds.
- R8: After stop release the flash warm-up does not begin until `osc_ready` is 1. The warm-up then has the full length of R4.
- R9: `irq_take` is 1 only when `irq_latched`=1, `irq_master_en`=1 and the block is in normal execution. It is never 1 while `cpu_wait` is 1.
- R10: `busy` equals `cpu_wait`, and `warm_en` equals `manual_en` AND `auto_en`.
- R11: The warm-up counter restarts from zero on every power-off, so each release waits the full length.
- R12: `halt_enter` or `stop_enter` strobes during a warm-up are ignored. The wait keeps its full length and ends in normal execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| manual_en | input | 1 | Manual flash power enable |
| auto_en | input | 1 | Automatic power-down enable for idle/sleep |
| clk_sel | input | 1 | 0: warm-up on fast clock, 1: on low-frequency tick |
| low_tick | input | 1 | One-cycle enable per low-frequency clock period |
| halt_enter | input | 1 | Idle/sleep entry strobe |
| halt_release | input | 1 | Idle/sleep release strobe |
| stop_enter | input | 1 | Stop entry strobe |
| stop_release | input | 1 | Stop release strobe |
| osc_ready | input | 1 | Oscillator warm-up finished |
| irq_latched | input | 1 | An interrupt request is latched |
| irq_master_en | input | 1 | Master interrupt enable |
| flash_pwr_on | output | 1 | Flash controller power enable |
| cpu_wait | output | 1 | CPU held in wait |
| busy | output | 1 | Warm-up in progress |
| warm_en | output | 1 | A warm-up will follow an idle/sleep release |
| irq_take | output | 1 | Latched interrupt may be serviced |

## Verification
Two events can coincide in one cycle: a latched interrupt and an active warm-up wait. The bench keeps `irq_latched` and `irq_master_en` high through every sweep case. In each cycle of a wait it checks that `irq_take` stays 0, and it checks that `irq_take` rises once normal execution resumes. The other coincidence is a mode-entry strobe landing in the middle of a warm-up. The bench injects a halt entry part-way through a count and judges it by the wait length, which must still be exactly 2^10, and by the state afterwards, which must be normal execution with power on.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_HALT_KEEP = 3'd1,
        ST_HALT_OFF  = 3'd2,
        ST_STOP_OFF  = 3'd3,
        ST_STOP_KEEP = 3'd4,
        ST_OSC_WARM  = 3'd5,
        ST_OSC_RUN   = 3'd6,
        ST_WARM      = 3'd7
    } pwr_state_e;
endpackage

// File: rtl/warm_counter.sv
module warm_counter #(
    parameter int HI_LOG2 = 10,
    parameter int LO_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_lo,
    input  logic low_tick,
    output logic done
);
    localparam int CW = (HI_LOG2 > LO_LOG2) ? HI_LOG2 : LO_LOG2;
    localparam logic [CW-1:0] HI_LAST = CW'((64'd1 << HI_LOG2) - 64'd1);
    localparam logic [CW-1:0] LO_LAST = CW'((64'd1 << LO_LOG2) - 64'd1);

    logic [CW-1:0] cnt_q;
    logic          tick;
    logic [CW-1:0] last;

    always_comb begin
        tick = sel_lo ? low_tick : 1'b1;
        last = sel_lo ? LO_LAST : HI_LAST;
        done = run && tick && (cnt_q == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R11: an idle counter is always back at zero
    assert_cnt_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import flash_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       manual_en,
    input  logic       auto_en,
    input  logic       halt_enter,
    input  logic       halt_release,
    input  logic       stop_enter,
    input  logic       stop_release,
    input  logic       osc_ready,
    input  logic       warm_done,
    output pwr_state_e state,
    output logic       flash_pwr_on,
    output logic       cpu_wait
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (stop_enter)
                    state_d = manual_en ? ST_STOP_OFF : ST_STOP_KEEP;
                else if (halt_enter)
                    state_d = (manual_en && auto_en) ? ST_HALT_OFF : ST_HALT_KEEP;
            end
            ST_HALT_KEEP: if (halt_release) state_d = ST_RUN;
            ST_HALT_OFF:  if (halt_release) state_d = ST_WARM;
            ST_STOP_OFF:  if (stop_release) state_d = ST_OSC_WARM;
            ST_STOP_KEEP: if (stop_release) state_d = ST_OSC_RUN;
            ST_OSC_WARM:  if (osc_ready)    state_d = ST_WARM;
            ST_OSC_RUN:   if (osc_ready)    state_d = ST_RUN;
            ST_WARM:      if (warm_done)    state_d = ST_RUN;
            default:                        state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state = state_q;
        unique case (state_q)
            ST_RUN, ST_HALT_KEEP: begin flash_pwr_on = manual_en; cpu_wait = 1'b0; end
            ST_WARM:              begin flash_pwr_on = 1'b1;      cpu_wait = 1'b1; end
            default:              begin flash_pwr_on = 1'b0;      cpu_wait = 1'b0; end
        endcase
    end

    // R8: no warm-up starts while the oscillator is still settling
    assert_osc_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OSC_WARM && !osc_ready) |=> !cpu_wait);
    // R12: a running warm-up is left only by counter overflow
    assert_warm_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM && !warm_done) |=> (state_q == ST_WARM));
    // R4: overflow returns to normal execution
    assert_warm_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WARM && warm_done) |=> (state_q == ST_RUN));
endmodule

// File: rtl/flash_pwr_seq.sv
module flash_pwr_seq
    import flash_pwr_pkg::*;
#(
    parameter int HI_LOG2 = 10,
    parameter int LO_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic manual_en,
    input  logic auto_en,
    input  logic clk_sel,
    input  logic low_tick,
    input  logic halt_enter,
    input  logic halt_release,
    input  logic stop_enter,
    input  logic stop_release,
    input  logic osc_ready,
    input  logic irq_latched,
    input  logic irq_master_en,
    output logic flash_pwr_on,
    output logic cpu_wait,
    output logic busy,
    output logic warm_en,
    output logic irq_take
);
    pwr_state_e state;
    logic       warm_done;

    pwr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .manual_en    (manual_en),
        .auto_en      (auto_en),
        .halt_enter   (halt_enter),
        .halt_release (halt_release),
        .stop_enter   (stop_enter),
        .stop_release (stop_release),
        .osc_ready    (osc_ready),
        .warm_done    (warm_done),
        .state        (state),
        .flash_pwr_on (flash_pwr_on),
        .cpu_wait     (cpu_wait)
    );

    warm_counter #(.HI_LOG2(HI_LOG2), .LO_LOG2(LO_LOG2)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cpu_wait),
        .sel_lo   (clk_sel),
        .low_tick (low_tick),
        .done     (warm_done)
    );

    assign busy     = cpu_wait;
    assign warm_en  = manual_en & auto_en;
    assign irq_take = irq_latched & irq_master_en & (state == ST_RUN);

    // R9: interrupts stay blocked during the wait
    assert_wait_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> !irq_take);
    // R4: the CPU only waits with flash powered
    assert_wait_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |-> flash_pwr_on);
    // R2: no manual enable means no flash power outside a warm-up
    assert_manual_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual_en && !busy) |-> !flash_pwr_on);
endmodule

// File: tb/flash_pwr_seq_tb.sv
module flash_pwr_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic manual_en = 1'b1, auto_en = 1'b0, clk_sel = 1'b0, low_tick = 1'b0;
    logic halt_enter = 1'b0, halt_release = 1'b0, stop_enter = 1'b0, stop_release = 1'b0;
    logic osc_ready = 1'b0, irq_latched = 1'b1, irq_master_en = 1'b1;
    logic flash_pwr_on, cpu_wait, busy, warm_en, irq_take;
    int checks = 0;
    int errors = 0;
    bit irq_bad;

    always #4 clk = ~clk;

    flash_pwr_seq u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_halt_enter();  halt_enter = 1;  @(negedge clk); halt_enter = 0;  endtask
    task automatic pulse_halt_rel();    halt_release = 1; @(negedge clk); halt_release = 0; endtask
    task automatic pulse_stop_enter();  stop_enter = 1;  @(negedge clk); stop_enter = 0;  endtask
    task automatic pulse_stop_rel();    stop_release = 1; @(negedge clk); stop_release = 0; endtask

    // counts negedges with cpu_wait high; injects a halt entry at sample inj
    task automatic count_wait(input int inj, output int n);
        n = 0;
        irq_bad = 0;
        while (cpu_wait && n < 3000) begin
            if (irq_take) irq_bad = 1;
            if (busy != cpu_wait) irq_bad = 1;
            halt_enter = (n == inj);
            n++;
            @(negedge clk);
        end
        halt_enter = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int exp_w;
        repeat (3) @(negedge clk);
        chk("R1 wait after reset", cpu_wait, 0);
        chk("R1 busy after reset", busy, 0);
        chk("R1 power after reset", flash_pwr_on, 1);
        rst_n = 1;
        @(negedge clk);

        // sweep: manual x auto x {halt, stop}
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 2; a++) begin
                for (int k = 0; k < 2; k++) begin
                    manual_en = m[0]; auto_en = a[0];
                    @(negedge clk);
                    chk("R10 warm_en", warm_en, m & a);
                    chk("R2 power in run", flash_pwr_on, m);
                    if (k == 0) begin
                        pulse_halt_enter();
                        chk((m == 0) ? "R2 halt power" : (a == 1) ? "R3 halt power" : "R6 halt power",
                            flash_pwr_on, m & ~a);
                        repeat (3) @(negedge clk);
                        pulse_halt_rel();
                        exp_w = (m & a) ? 1024 : 0;
                    end else begin
                        pulse_stop_enter();
                        chk((m == 1) ? "R7 stop power" : "R2 stop power", flash_pwr_on, 0);
                        pulse_stop_rel();
                        repeat (5) @(negedge clk);
                        chk("R8 no wait before osc_ready", cpu_wait, 0);
                        osc_ready = 1; @(negedge clk); osc_ready = 0;
                        exp_w = m ? 1024 : 0;
                    end
                    count_wait(-1, n);
                    chk((exp_w == 0) ? "R6 wait length" : "R4 wait length", n, exp_w);
                    chk("R9 no irq during wait", irq_bad, 0);
                    chk("R4 power after", flash_pwr_on, m);
                    chk("R9 irq taken in run", irq_take, 1);
                end
            end
        end

        // R11: back-to-back release gives the full count again
        manual_en = 1; auto_en = 1;
        pulse_halt_enter(); pulse_halt_rel();
        count_wait(-1, n);
        chk("R11 second full count", n, 1024);

        // R12: entry during warm-up ignored
        pulse_halt_enter(); pulse_halt_rel();
        count_wait(100, n);
        chk("R12 wait length with entry", n, 1024);
        repeat (2) @(negedge clk);
        chk("R12 back in run", cpu_wait, 0);
        chk("R12 power on", flash_pwr_on, 1);

        // R5: low-frequency warm-up
        clk_sel = 1;
        pulse_halt_enter(); pulse_halt_rel();
        n = 0;
        for (int c = 0; c < 200 && cpu_wait; c++) begin
            low_tick = (c % 4 == 0);
            if (low_tick) n++;
            @(negedge clk);
        end
        low_tick = 0;
        chk("R5 low ticks during wait", n, 8);
        chk("R5 wait ended", cpu_wait, 0);
        clk_sel = 0;

        // R9: master enable off blocks irq
        irq_master_en = 0;
        @(negedge clk);
        chk("R9 master disabled", irq_take, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule